// File: doc/BRIEF.md
# Long-Press Power Key Controller

This block turns a single push key into power control for an always-on domain. The key input is low at rest and high while pressed. Each press is timed in millisecond ticks, and what a press does depends on how long it lasts and on the power state at the time. The block tracks three states: off, running and napping (deep sleep). A press can switch the domain on, put it into a nap, wake it, or switch it off.

Apart from these per-state rules, a hardware override forces power off once the key has been held for ten seconds, whatever the state. The key first goes through a two-flop synchronizer and a 10 ms debounce filter, so bounce and short glitches are never timed.

The outputs are the power-enable level, a one-cycle nap request and a one-cycle wake request. Software uses the two requests to enter or leave its suspend path.

Top module: `pwr_key_ctrl`

## Requirements
- R1: After reset, `pwrEn`, `sleepReq` and `resumeReq` are all low, and the block is in the off state.
- R2: A key pulse shorter than `DEBOUNCE_MS` milliseconds is ignored. Power level, requests and state do not change.
- R3: In the off state, once the debounced key has been held high for `ON_MS` milliseconds, `pwrEn` goes high while the key is still held, and the block enters the running state.
- R4: In the running state, releasing the key after a hold of at least `SLEEP_MS` and less than `OFF_MS` milliseconds enters the napping state. `sleepReq` pulses once and `pwrEn` stays high.
- R5: In the running state, when the hold reaches `OFF_MS` milliseconds, `pwrEn` goes low while the key is still held, and no `sleepReq` is given for that press.
- R6: In the napping state, when the hold reaches `RESUME_MS` milliseconds, `resumeReq` pulses once, the block returns to the running state, and `pwrEn` stays high.
- R7: A hold that reaches `FORCE_MS` milliseconds drives `pwrEn` low in every state. This includes a press that earlier in the same hold already switched the domain on or woke it.
- R8: A press triggers at most one of on, nap, wake or off. After one of these actions, no further action is taken until the key has been seen released, except the R7 override.
- R9: A press shorter than the threshold that applies in the current state leaves the state and outputs unchanged.
- R10: Hold time is counted in ticks of `TICK_DIV` clock cycles (1 ms each). The counter saturates at `FORCE_MS`, so it can never wrap.
- R11: `sleepReq` and `resumeReq` are each exactly one cycle wide and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keyIn | input | 1 | Raw push key, high while pressed |
| pwrEn | output | 1 | Power enable for the always-on domain |
| sleepReq | output | 1 | One-cycle request to enter the nap state |
| resumeReq | output | 1 | One-cycle request to leave the nap state |

## Verification
In the running state, the nap decision (taken on release) and the power-off threshold (taken while the key is held) can land on neighbouring ticks of the same press. A hold that ends just at the off threshold could therefore yield both a nap request and a power drop. The bench sweeps press length one millisecond at a time across that boundary, and across every other threshold, from each starting state. It skips only lengths within one tick of a threshold, where tick phase decides the outcome. Each press is judged by counting both request pulses and reading the final power level: exactly one of "one nap pulse with power on" or "power off with no pulse" must appear.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

  typedef enum logic [1:0] {
    PWR_OFF = 2'd0,
    PWR_RUN = 2'd1,
    PWR_NAP = 2'd2
  } pwrState_t;

  // Strobes and levels the datapath hands to the controller each cycle.
  typedef struct packed {
    logic keyLvl;    // debounced key level
    logic keyFall;   // one-cycle strobe: debounced release
    logic atResume;  // hold has reached the wake threshold
    logic atOn;      // hold has reached the power-on threshold
    logic atSleep;   // hold has reached the nap threshold
    logic atOff;     // hold has reached the power-off threshold
    logic atForce;   // hold has reached the forced-off threshold
  } keyEvents_t;

endpackage

// File: rtl/pkc_sync.sv
module pkc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pkc_datapath.sv
module pkc_datapath
  import pkc_pkg::*;
#(
  parameter int TICK_DIV    = 100000,
  parameter int DEBOUNCE_MS = 10,
  parameter int RESUME_MS   = 300,
  parameter int ON_MS       = 1000,
  parameter int SLEEP_MS    = 1000,
  parameter int OFF_MS      = 7000,
  parameter int FORCE_MS    = 10000,
  localparam int DIV_W      = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam int DEB_W      = (DEBOUNCE_MS > 1) ? $clog2(DEBOUNCE_MS + 1) : 1,
  localparam int HOLD_W     = $clog2(FORCE_MS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keyIn,
  output keyEvents_t        events,
  output logic [HOLD_W-1:0] holdMs
);

  // ---------------- input synchronizer ----------------
  logic keySync;

  pkc_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (keyIn),
    .q     (keySync)
  );

  // ---------------- millisecond prescaler ----------------
  logic [DIV_W-1:0] divCnt;
  logic             msTick;

  assign msTick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      divCnt <= '0;
    else if (msTick) divCnt <= '0;
    else             divCnt <= divCnt + DIV_W'(1);
  end

  // ---------------- debounce filter ----------------
  // The level only follows the synchronized key after it has disagreed
  // for DEBOUNCE_MS consecutive ticks; any agreement restarts the count.
  logic [DEB_W-1:0] debCnt;
  logic             keyLvl;
  logic             keyLvlD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debCnt  <= '0;
      keyLvl  <= 1'b0;
      keyLvlD <= 1'b0;
    end else begin
      keyLvlD <= keyLvl;
      if (keySync == keyLvl) begin
        debCnt <= '0;
      end else if (msTick) begin
        if (debCnt == DEB_W'(DEBOUNCE_MS - 1)) begin
          keyLvl <= keySync;
          debCnt <= '0;
        end else begin
          debCnt <= debCnt + DEB_W'(1);
        end
      end
    end
  end

  // ---------------- saturating hold counter ----------------
  // Cleared one cycle after the debounced release, so the controller
  // still sees the full hold in the release cycle.
  logic holdFull;

  assign holdFull = (holdMs == HOLD_W'(FORCE_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    holdMs <= '0;
    else if (!keyLvl)              holdMs <= '0;
    else if (msTick && !holdFull)  holdMs <= holdMs + HOLD_W'(1);
  end

  // ---------------- threshold decode ----------------
  always_comb begin
    events.keyLvl   = keyLvl;
    events.keyFall  = keyLvlD & ~keyLvl;
    events.atResume = (holdMs >= HOLD_W'(RESUME_MS));
    events.atOn     = (holdMs >= HOLD_W'(ON_MS));
    events.atSleep  = (holdMs >= HOLD_W'(SLEEP_MS));
    events.atOff    = (holdMs >= HOLD_W'(OFF_MS));
    events.atForce  = holdFull;
  end

endmodule

// File: rtl/pkc_control.sv
module pkc_control
  import pkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  keyEvents_t events,
  output logic       pwrEn,
  output logic       sleepReq,
  output logic       resumeReq
);

  pwrState_t state;
  logic      armed;   // a new press may still trigger an action

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PWR_OFF;
      armed     <= 1'b0;
      sleepReq  <= 1'b0;
      resumeReq <= 1'b0;
    end else begin
      sleepReq  <= 1'b0;
      resumeReq <= 1'b0;

      if (events.keyLvl && events.atForce) begin
        // hardware override: wins over every per-state rule
        state <= PWR_OFF;
        armed <= 1'b0;
      end else if (!events.keyLvl) begin
        armed <= 1'b1;
        if (armed && events.keyFall && (state == PWR_RUN) &&
            events.atSleep && !events.atOff) begin
          state    <= PWR_NAP;
          sleepReq <= 1'b1;
        end
      end else if (armed) begin
        unique case (state)
          PWR_OFF: begin
            if (events.atOn) begin
              state <= PWR_RUN;
              armed <= 1'b0;
            end
          end
          PWR_RUN: begin
            if (events.atOff) begin
              state <= PWR_OFF;
              armed <= 1'b0;
            end
          end
          PWR_NAP: begin
            if (events.atResume) begin
              state     <= PWR_RUN;
              resumeReq <= 1'b1;
              armed     <= 1'b0;
            end
          end
          default: begin
            state <= PWR_OFF;
            armed <= 1'b0;
          end
        endcase
      end
    end
  end

  assign pwrEn = (state != PWR_OFF);

endmodule

// File: rtl/pwr_key_ctrl.sv
module pwr_key_ctrl
  import pkc_pkg::*;
#(
  parameter int TICK_DIV    = 100000,
  parameter int DEBOUNCE_MS = 10,
  parameter int RESUME_MS   = 300,
  parameter int ON_MS       = 1000,
  parameter int SLEEP_MS    = 1000,
  parameter int OFF_MS      = 7000,
  parameter int FORCE_MS    = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic keyIn,
  output logic pwrEn,
  output logic sleepReq,
  output logic resumeReq
);

  localparam int HOLD_W = $clog2(FORCE_MS + 1);

  keyEvents_t        events;
  logic [HOLD_W-1:0] holdMs;
  logic              keyLvl;

  assign keyLvl = events.keyLvl;

  pkc_datapath #(
    .TICK_DIV    (TICK_DIV),
    .DEBOUNCE_MS (DEBOUNCE_MS),
    .RESUME_MS   (RESUME_MS),
    .ON_MS       (ON_MS),
    .SLEEP_MS    (SLEEP_MS),
    .OFF_MS      (OFF_MS),
    .FORCE_MS    (FORCE_MS)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .keyIn  (keyIn),
    .events (events),
    .holdMs (holdMs)
  );

  pkc_control u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .events    (events),
    .pwrEn     (pwrEn),
    .sleepReq  (sleepReq),
    .resumeReq (resumeReq)
  );

endmodule

// File: rtl/pkc_checker.sv
module pkc_checker #(
  parameter int HOLD_W   = 14,
  parameter int ON_MS    = 1000,
  parameter int OFF_MS   = 7000,
  parameter int FORCE_MS = 10000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              keyLvl,
  input logic [HOLD_W-1:0] holdMs,
  input logic              pwrEn,
  input logic              sleepReq,
  input logic              resumeReq
);

  a_r11_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleepReq && resumeReq));

  a_r11_sleep_single: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |=> !sleepReq);

  a_r11_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resumeReq |=> !resumeReq);

  a_r4_sleep_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> pwrEn);

  a_r4_sleep_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> !$past(keyLvl));

  a_r6_resume_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    resumeReq |-> pwrEn);

  a_r3_on_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrEn) |-> ($past(keyLvl) && ($past(holdMs) >= HOLD_W'(ON_MS))));

  a_r5_off_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwrEn) |-> ($past(holdMs) >= HOLD_W'(OFF_MS)));

  a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    (keyLvl && (holdMs >= HOLD_W'(FORCE_MS))) |=> !pwrEn);

  a_r10_hold_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    holdMs <= HOLD_W'(FORCE_MS));

  a_r10_hold_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (keyLvl && $past(keyLvl)) |-> (holdMs >= $past(holdMs)));

endmodule

bind pwr_key_ctrl pkc_checker #(
  .HOLD_W   (HOLD_W),
  .ON_MS    (ON_MS),
  .OFF_MS   (OFF_MS),
  .FORCE_MS (FORCE_MS)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .keyLvl    (keyLvl),
  .holdMs    (holdMs),
  .pwrEn     (pwrEn),
  .sleepReq  (sleepReq),
  .resumeReq (resumeReq)
);

// File: tb/pwr_key_ctrl_bench.sv
module pwr_key_ctrl_bench;

  localparam int DIV  = 4;
  localparam int DEB  = 3;
  localparam int RES  = 4;
  localparam int ONT  = 8;
  localparam int SLP  = 8;
  localparam int OFFT = 14;
  localparam int FRC  = 22;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic keyIn = 1'b0;
  logic pwrEn, sleepReq, resumeReq;

  int  total = 0;
  int  bad   = 0;
  int  sleepCnt  = 0;
  int  resumeCnt = 0;
  bit  sawHigh   = 1'b0;
  bit  done      = 1'b0;

  always #5 clk = ~clk;

  pwr_key_ctrl #(
    .TICK_DIV    (DIV),
    .DEBOUNCE_MS (DEB),
    .RESUME_MS   (RES),
    .ON_MS       (ONT),
    .SLEEP_MS    (SLP),
    .OFF_MS      (OFFT),
    .FORCE_MS    (FRC)
  ) u_pwr_key_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .keyIn     (keyIn),
    .pwrEn     (pwrEn),
    .sleepReq  (sleepReq),
    .resumeReq (resumeReq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sleepReq)  sleepCnt++;
      if (resumeReq) resumeCnt++;
      if (pwrEn)     sawHigh = 1'b1;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // hold the key for ms milliseconds, then release and let it settle
  task automatic press(int ms);
    @(negedge clk) keyIn = 1'b1;
    repeat (ms * DIV) @(negedge clk);
    keyIn = 1'b0;
    repeat ((DEB + 6) * DIV) @(negedge clk);
  endtask

  task automatic clearCounts();
    sleepCnt  = 0;
    resumeCnt = 0;
    sawHigh   = 1'b0;
  endtask

  // a length whose outcome hinges on tick phase is skipped
  function automatic bit ambiguous(int k);
    int th[5];
    th = '{RES, ONT, SLP, OFFT, FRC};
    if (k >= 2 && k <= DEB + 1) return 1'b1;
    foreach (th[i]) if (th[i] > k - 1 && th[i] <= k + 1) return 1'b1;
    return 1'b0;
  endfunction

  // state codes used by the bench model: 0 off, 1 running, 2 napping
  task automatic goState(int st);
    press(FRC + 3);                       // R7: forced off from anywhere
    check("R7", int'(pwrEn), 0);
    if (st >= 1) begin
      press(ONT + 3);                     // R3: switch on
      check("R3", int'(pwrEn), 1);
    end
    if (st == 2) begin
      clearCounts();
      press(SLP + 3);                     // R4: nap on release
      check("R4", sleepCnt, 1);
      check("R4", int'(pwrEn), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(pwrEn), 0);
    check("R1", int'(sleepReq), 0);
    check("R1", int'(resumeReq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'(pwrEn), 0);

    for (int st = 0; st < 3; st++) begin
      for (int k = 1; k <= FRC + 4; k++) begin
        int    h;
        int    expPwr, expSlp, expRes, expSaw;
        string tag;
        if (ambiguous(k)) continue;
        h = (k == 1) ? 0 : k;
        expSlp = 0; expRes = 0; expSaw = -1;
        if (st == 0) begin
          expPwr = (h >= ONT && h < FRC) ? 1 : 0;
          expSaw = (h >= ONT) ? 1 : 0;
          tag = (k == 1) ? "R2" : (h >= FRC) ? "R7" : (h >= OFFT) ? "R8" :
                (h >= ONT) ? "R3" : "R9";
        end else if (st == 1) begin
          expPwr = (h >= OFFT) ? 0 : 1;
          expSlp = (h >= SLP && h < OFFT) ? 1 : 0;
          tag = (k == 1) ? "R2" : (h >= OFFT) ? "R5" : (h >= SLP) ? "R4" : "R9";
        end else begin
          expPwr = (h >= FRC) ? 0 : 1;
          expRes = (h >= RES) ? 1 : 0;
          tag = (k == 1) ? "R2" : (h >= FRC) ? "R7" : (h >= SLP) ? "R8" :
                (h >= RES) ? "R6" : "R9";
        end
        goState(st);
        clearCounts();
        press(k);
        check(tag, int'(pwrEn), expPwr);
        check({tag, " R11 sleep pulses"}, sleepCnt, expSlp);
        check({tag, " R11 resume pulses"}, resumeCnt, expRes);
        if (expSaw >= 0) check({tag, " on while held"}, int'(sawHigh), expSaw);
        // a released nap/run state is told apart by a follow-up wake press
        if (expPwr == 1) begin
          clearCounts();
          press(RES + 2);
          check({tag, " R9 state probe"}, resumeCnt, (st == 2 && h < RES) || (st == 1 && expSlp == 1) ? 1 : 0);
        end
      end
    end

    // R10: a hold far past the override must not wrap and re-trigger
    goState(1);
    clearCounts();
    press(2 * FRC + 10);
    check("R10", int'(pwrEn), 0);
    check("R10", int'(sawHigh), 1);
    check("R10", sleepCnt + resumeCnt, 0);

    // R8: a power-on press held well past the nap window gives no nap
    goState(0);
    clearCounts();
    press(OFFT + 3);
    check("R8", int'(pwrEn), 1);
    check("R8", sleepCnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule